// File: doc/BRIEF.md
# Reset Fetch Address Upper-Line Forcing

This block sits between a processor's code address adder and its bus interface. After reset, a sticky mode bit drives the twelve most significant lines of every instruction-fetch address to one. The first fetch therefore lands just below the top of the 4 GB space, where a boot ROM can live. Jumps and calls within the current segment leave the mode set, so execution stays in the top 64 KB window. The first jump or call to another segment clears the mode, and from then on fetch addresses pass through unchanged until the next reset.

Data-access addresses travel through a parallel path that is never forced. Both paths are registered, with one cycle of latency. The block also drives the architectural reset values as constant outputs: code selector, hidden code base, instruction pointer, flags, and interrupt table base and limit. Other logic uses these to load its registers.

Top module: `fetch_addr_force`

## Requirements
- R1: While rst_ni is low and after it is released, force_active_o is 1, and fetch_vld_o, data_vld_o, fetch_addr_o and data_addr_o are 0 until the first strobe.
- R2: The reset value outputs are constant: rst_ip_o = 32'h0000FFF0, rst_cs_sel_o = 16'h0000, rst_cs_base_o = 32'hFFFF0000.
- R3: The reset value outputs are constant: rst_flags_o = 32'h00000002 (bit 1 set, interrupt enable bit 9 clear), rst_idt_base_o = 32'h0, rst_idt_limit_o = 16'h03FF.
- R4: A fetch strobe (fetch_req_i high at a rising edge) produces fetch_vld_o high for the following cycle. While forcing is active, fetch_addr_o[31:20] is then all ones and fetch_addr_o[19:0] equals fetch_lin_i[19:0]. Without a strobe, fetch_vld_o is 0.
- R5: Right after reset, a fetch of rst_cs_base_o + rst_ip_o gives fetch_addr_o = 32'hFFFFFFF0.
- R6: A near transfer pulse (near_xfer_i) without a far pulse leaves force_active_o at 1.
- R7: A far transfer pulse (far_xfer_i) makes force_active_o 0 from the next cycle. A fetch strobed in the same cycle as the pulse is still forced. Later fetches give fetch_addr_o equal to fetch_lin_i.
- R8: Once cleared, forcing stays cleared through any further near or far pulses until rst_ni goes low. If both pulses arrive in the same cycle, the far pulse wins.
- R9: A data strobe (data_req_i) gives data_vld_o high for the next cycle, with data_addr_o equal to data_lin_i, whatever the forcing state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_req_i | input | 1 | Instruction fetch strobe |
| fetch_lin_i | input | 32 | Computed fetch address (code base + pointer) |
| near_xfer_i | input | 1 | Intrasegment jump/call pulse |
| far_xfer_i | input | 1 | Intersegment jump/call pulse |
| data_req_i | input | 1 | Data access strobe |
| data_lin_i | input | 32 | Data access address |
| fetch_vld_o | output | 1 | Fetch address valid |
| fetch_addr_o | output | 32 | Physical fetch address |
| data_vld_o | output | 1 | Data address valid |
| data_addr_o | output | 32 | Physical data address |
| force_active_o | output | 1 | Upper-line forcing mode is set |
| rst_ip_o | output | 32 | Reset instruction pointer |
| rst_cs_sel_o | output | 16 | Reset code selector |
| rst_cs_base_o | output | 32 | Reset hidden code base |
| rst_flags_o | output | 32 | Reset flags value |
| rst_idt_base_o | output | 32 | Reset interrupt table base |
| rst_idt_limit_o | output | 16 | Reset interrupt table limit |

## Verification
The bench targets a fetch that arrives in the same cycle as the far pulse. A design that applies the clear combinationally would send that fetch to the low address. It also checks that far pulses arriving after the clear leave forcing off, and that a near and a far pulse in the same cycle clear forcing; a design that toggled the mode or gave near priority would restore the forced high addresses. A data access runs alongside every forced fetch, which exposes a design that forces the data path as well. After a mid-run reset, the bench checks that forcing comes back on and that the boot address is again FFFFFFF0h.

// File: rtl/fetch_addr_force_pkg.sv
package fetch_addr_force_pkg;
  localparam int unsigned ADDR_W      = 32;
  localparam int unsigned SEL_W       = 16;
  localparam int unsigned FORCE_LSB   = 20;
  localparam logic [31:0] RST_IP      = 32'h0000_FFF0;
  localparam logic [15:0] RST_CS_SEL  = 16'h0000;
  localparam logic [31:0] RST_CS_BASE = 32'hFFFF_0000;
  localparam logic [31:0] RST_FLAGS   = 32'h0000_0002;
  localparam logic [31:0] RST_IDT_BS  = 32'h0000_0000;
  localparam logic [15:0] RST_IDT_LIM = 16'h03FF;
endpackage

// File: rtl/fa_mode_reg.sv
module fa_mode_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic far_xfer_i,
  output logic force_o
);
  // sticky: set only by reset, cleared by a far transfer
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         force_o <= 1'b1;
    else if (far_xfer_i) force_o <= 1'b0;
  end
endmodule

// File: rtl/fa_line_force.sv
module fa_line_force #(
  parameter int unsigned ADDR_W    = 32,
  parameter int unsigned FORCE_LSB = 20
) (
  input  logic              force_i,
  input  logic [ADDR_W-1:0] addr_i,
  output logic [ADDR_W-1:0] addr_o
);
  for (genvar b = 0; b < ADDR_W; b++) begin : g_bit
    if (b >= FORCE_LSB) begin : g_forced
      assign addr_o[b] = addr_i[b] | force_i;
    end else begin : g_pass
      assign addr_o[b] = addr_i[b];
    end
  end
endmodule

// File: rtl/fetch_addr_force.sv
module fetch_addr_force
  import fetch_addr_force_pkg::*;
(
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        fetch_req_i,
  input  logic [31:0] fetch_lin_i,
  input  logic        near_xfer_i,
  input  logic        far_xfer_i,
  input  logic        data_req_i,
  input  logic [31:0] data_lin_i,
  output logic        fetch_vld_o,
  output logic [31:0] fetch_addr_o,
  output logic        data_vld_o,
  output logic [31:0] data_addr_o,
  output logic        force_active_o,
  output logic [31:0] rst_ip_o,
  output logic [15:0] rst_cs_sel_o,
  output logic [31:0] rst_cs_base_o,
  output logic [31:0] rst_flags_o,
  output logic [31:0] rst_idt_base_o,
  output logic [15:0] rst_idt_limit_o
);
  logic              force_q;
  logic [ADDR_W-1:0] fetch_phys;

  fa_mode_reg i_mode (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .far_xfer_i(far_xfer_i),
    .force_o   (force_q)
  );

  fa_line_force #(.ADDR_W(ADDR_W), .FORCE_LSB(FORCE_LSB)) i_force (
    .force_i(force_q),
    .addr_i (fetch_lin_i),
    .addr_o (fetch_phys)
  );

  // near transfers deliberately have no effect on the mode
  logic near_unused;
  assign near_unused = near_xfer_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fetch_vld_o  <= 1'b0;
      fetch_addr_o <= '0;
      data_vld_o   <= 1'b0;
      data_addr_o  <= '0;
    end else begin
      fetch_vld_o <= fetch_req_i;
      data_vld_o  <= data_req_i;
      if (fetch_req_i) fetch_addr_o <= fetch_phys;
      if (data_req_i)  data_addr_o  <= data_lin_i;
    end
  end

  assign force_active_o  = force_q;
  assign rst_ip_o        = RST_IP;
  assign rst_cs_sel_o    = RST_CS_SEL;
  assign rst_cs_base_o   = RST_CS_BASE;
  assign rst_flags_o     = RST_FLAGS;
  assign rst_idt_base_o  = RST_IDT_BS;
  assign rst_idt_limit_o = RST_IDT_LIM;
endmodule

// File: rtl/fa_checker.sv
module fa_checker (
  input logic        clk_i,
  input logic        rst_ni,
  input logic        fetch_req_i,
  input logic [31:0] fetch_lin_i,
  input logic        near_xfer_i,
  input logic        far_xfer_i,
  input logic        data_req_i,
  input logic [31:0] data_lin_i,
  input logic        fetch_vld_o,
  input logic [31:0] fetch_addr_o,
  input logic        data_vld_o,
  input logic [31:0] data_addr_o,
  input logic        force_active_o
);
  AST_FETCH_VALID: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fetch_req_i |=> fetch_vld_o); // R4
  AST_FORCED_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && force_active_o) |=> (fetch_addr_o[31:20] == 12'hFFF
      && fetch_addr_o[19:0] == $past(fetch_lin_i[19:0]))); // R4
  AST_NEAR_KEEPS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (force_active_o && near_xfer_i && !far_xfer_i) |=> force_active_o); // R6
  AST_FAR_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    far_xfer_i |=> !force_active_o); // R7
  AST_PASS_THROUGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fetch_req_i && !force_active_o) |=> fetch_addr_o == $past(fetch_lin_i)); // R7
  AST_STICKY_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !force_active_o |=> !force_active_o); // R8
  AST_DATA_UNFORCED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    data_req_i |=> (data_vld_o && data_addr_o == $past(data_lin_i))); // R9
endmodule

bind fetch_addr_force fa_checker i_fa_checker (
  .clk_i         (clk_i),
  .rst_ni        (rst_ni),
  .fetch_req_i   (fetch_req_i),
  .fetch_lin_i   (fetch_lin_i),
  .near_xfer_i   (near_xfer_i),
  .far_xfer_i    (far_xfer_i),
  .data_req_i    (data_req_i),
  .data_lin_i    (data_lin_i),
  .fetch_vld_o   (fetch_vld_o),
  .fetch_addr_o  (fetch_addr_o),
  .data_vld_o    (data_vld_o),
  .data_addr_o   (data_addr_o),
  .force_active_o(force_active_o)
);

// File: tb/test_fetch_addr_force.sv
module test_fetch_addr_force;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fetch_req = 1'b0, near_x = 1'b0, far_x = 1'b0, data_req = 1'b0;
  logic [31:0] fetch_lin = '0, data_lin = '0;
  logic        fetch_vld, data_vld, force_act;
  logic [31:0] fetch_addr, data_addr, r_ip, r_cs_base, r_flags, r_idt_base;
  logic [15:0] r_cs_sel, r_idt_lim;

  int checks = 0, errors = 0;
  bit model_force;
  bit done = 1'b0;

  always #2 clk = ~clk;

  fetch_addr_force i_fetch_addr_force (
    .clk_i(clk), .rst_ni(rst_n),
    .fetch_req_i(fetch_req), .fetch_lin_i(fetch_lin),
    .near_xfer_i(near_x), .far_xfer_i(far_x),
    .data_req_i(data_req), .data_lin_i(data_lin),
    .fetch_vld_o(fetch_vld), .fetch_addr_o(fetch_addr),
    .data_vld_o(data_vld), .data_addr_o(data_addr),
    .force_active_o(force_act),
    .rst_ip_o(r_ip), .rst_cs_sel_o(r_cs_sel), .rst_cs_base_o(r_cs_base),
    .rst_flags_o(r_flags), .rst_idt_base_o(r_idt_base), .rst_idt_limit_o(r_idt_lim)
  );

  function automatic logic [31:0] exp_fetch(input logic [31:0] a, input bit f);
    return f ? (a | 32'hFFF0_0000) : a;
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one cycle: drive on negedge, sample 1 ns after the rising edge
  task automatic cyc(input bit fr, input logic [31:0] fa, input bit nr, input bit fx,
                     input bit dr, input logic [31:0] da, input string req);
    bit old_f;
    @(negedge clk);
    fetch_req = fr; fetch_lin = fa; near_x = nr; far_x = fx;
    data_req = dr; data_lin = da;
    old_f = model_force;
    @(posedge clk); #1;
    if (fx) model_force = 1'b0;
    chk({req, " vld"}, {31'b0, fetch_vld}, {31'b0, fr});
    if (fr) chk({req, " fetch"}, fetch_addr, exp_fetch(fa, old_f));
    if (dr) chk("R9 data", data_addr, da);
    chk({req, " mode"}, {31'b0, force_act}, {31'b0, model_force});
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    fetch_req = 0; near_x = 0; far_x = 0; data_req = 0;
    #1;
    model_force = 1'b1;
    chk("R1 mode in reset", {31'b0, force_act}, 32'd1);
    chk("R1 fetch addr", fetch_addr, 32'h0);
    chk("R1 data addr", data_addr, 32'h0);
    chk("R1 vld", {30'b0, fetch_vld, data_vld}, 32'h0);
    @(negedge clk); rst_n = 1'b1;
    @(posedge clk); #1;
    chk("R1 mode after release", {31'b0, force_act}, 32'd1);
  endtask

  initial begin
    #400000;
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    model_force = 1'b1;
    do_reset();
    // R2 / R3 constants
    chk("R2 ip", r_ip, 32'h0000FFF0);
    chk("R2 cs sel", {16'b0, r_cs_sel}, 32'h0);
    chk("R2 cs base", r_cs_base, 32'hFFFF0000);
    chk("R3 flags", r_flags, 32'h00000002);
    chk("R3 idt base", r_idt_base, 32'h0);
    chk("R3 idt limit", {16'b0, r_idt_lim}, 32'h03FF);
    // R5 boot address
    cyc(1, r_cs_base + r_ip, 0, 0, 0, '0, "R5");
    chk("R5 boot", fetch_addr, 32'hFFFFFFF0);
    // R4 idle: no strobe gives no valid
    cyc(0, 32'h1234_5678, 0, 0, 1, 32'h0000_0100, "R4 idle");
    // R4/R6/R9 random near traffic while forced
    for (int i = 0; i < 200; i++)
      cyc($urandom_range(0, 1), $urandom, $urandom_range(0, 1), 0,
          $urandom_range(0, 1), $urandom, "R6");
    // R7: fetch coincident with far pulse is still forced
    cyc(1, 32'h0001_2345, 0, 1, 1, 32'h000F_0000, "R7 same cycle");
    chk("R7 coincident", fetch_addr, 32'hFFF1_2345);
    cyc(1, 32'h0001_2345, 0, 0, 0, '0, "R7 after");
    chk("R7 low", fetch_addr, 32'h0001_2345);
    // R8: further far/near pulses leave forcing off
    for (int i = 0; i < 200; i++)
      cyc($urandom_range(0, 1), $urandom, $urandom_range(0, 1),
          $urandom_range(0, 1), $urandom_range(0, 1), $urandom, "R8");
    // R8: reset restores, then simultaneous near and far clears
    do_reset();
    cyc(1, 32'h0000_FFF0, 1, 1, 0, '0, "R8 both");
    cyc(1, 32'h0000_FFF0, 0, 0, 0, '0, "R8 both after");
    chk("R8 far wins", fetch_addr, 32'h0000_FFF0);
    do_reset();
    cyc(1, r_cs_base + r_ip, 0, 0, 0, '0, "R5 rerun");
    chk("R5 boot after reset", fetch_addr, 32'hFFFFFFF0);
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule